// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block connects a 32-bit integer datapath to a byte-addressed data memory that is organised as 32-bit words. For each request it takes an access size, a load/store direction, a signedness choice for loads, a base register value, a 16-bit displacement and the store data. It forms the effective address and presents a word-aligned memory address. For stores it also presents per-lane byte enables and write data with the value placed on its lanes.

Lanes are numbered big-endian, so the byte at word offset 0 occupies bits 31:24. When a load is issued, the memory returns the word one cycle later. The unit then picks the addressed byte or halfword from that word, extends it to 32 bits with sign or zero fill as the request asked, and presents the result with a valid strobe. An access whose address is not a multiple of its size raises a misalign flag. A misaligned request does not reach the memory, and a misaligned load returns zero.

Top module: `be_lane_unit`

## Requirements
- R1: The effective address is `base` plus the 16-bit displacement sign-extended to 32 bits. `mem_addr` equals that address with bits 1:0 forced to zero.
- R2: `misalign` is high during a valid request when the size is halfword (`size`=01) and address bit 0 is set, or when the size is word (`size`=10, or the unused code 11) and address bits 1:0 are not 00. A byte access (`size`=00) is never misaligned.
- R3: A misaligned request drives `mem_be` to 0000 and `mem_re` low. A misaligned load still returns a result one cycle later, and that result is zero.
- R4: An aligned store sets byte enables in big-endian order, with `mem_be` bit 3 standing for offset 0. A byte store at offset k sets only bit 3-k. A halfword store gives 1100 at offset 0 and 0011 at offset 2. A word store gives 1111.
- R5: For stores, `mem_wdata` repeats the byte on all four lanes or the halfword on both halves. A word is passed through unchanged.
- R6: A load request drives `mem_re` only when it is aligned. Exactly one cycle after any load request, `ld_valid` is high for one cycle. `ld_data` then holds the addressed lanes of `mem_rdata`: byte at offset k is bits 31-8k down to 24-8k, the halfword at offset 0 is bits 31:16 and the halfword at offset 2 is bits 15:0. A word load returns the whole word.
- R7: A signed load (`unsigned_ld`=0) copies the top bit of the selected byte or halfword into every upper bit. For example, byte 0x8C loads as 0xFFFFFF8C.
- R8: An unsigned load (`unsigned_ld`=1) fills the upper bits of a byte or halfword with zeros.
- R9: While reset is asserted `ld_valid` is low. With `req_valid` low, `mem_be` is 0000 and both `mem_re` and `misalign` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| unsigned_ld | input | 1 | Zero-extend narrow loads when set |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 32 | Store data, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_be | output | 4 | Byte write enables, bit 3 = lane at offset 0 |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Word returned one cycle after `mem_re` |
| misalign | output | 1 | Current request is misaligned |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Loads are swept over all four offsets and all five load kinds, using memory words whose bytes and halfwords mix set and clear top bits. A lane taken from the wrong end of the word, or a swapped extension mode, therefore gives a different value. Stores are driven at every offset for each size, which checks enable placement separately from lane replication. Odd and near-aligned addresses exercise the misalign rules, including the zero return for a misaligned load. Negative displacements that carry or borrow into the upper address bits check the effective-address sign extension.

// File: rtl/be_lane_unit.sv
module be_lane_unit #(
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              unsigned_ld,
  input  logic [31:0]       base,
  input  logic [DISP_W-1:0] disp,
  input  logic [31:0]       st_data,
  output logic [31:0]       mem_addr,
  output logic              mem_re,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              misalign,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  localparam logic [1:0] SZ_B = 2'b00;
  localparam logic [1:0] SZ_H = 2'b01;

  logic [31:0] ea;
  logic [1:0]  off;
  logic        bad;
  logic [3:0]  be_raw;

  assign ea  = base + {{(32-DISP_W){disp[DISP_W-1]}}, disp};
  assign off = ea[1:0];
  assign bad = (req_size == SZ_H) ? off[0] :
               (req_size == SZ_B) ? 1'b0 : (off != 2'b00);

  assign mem_addr = {ea[31:2], 2'b00};
  assign misalign = req_valid & bad;
  assign mem_re   = req_valid & ~req_store & ~bad;

  always_comb begin
    case (req_size)
      SZ_B:    be_raw = 4'b1000 >> off;
      SZ_H:    be_raw = off[1] ? 4'b0011 : 4'b1100;
      default: be_raw = 4'b1111;
    endcase
  end
  assign mem_be = (req_valid & req_store & ~bad) ? be_raw : 4'b0000;

  always_comb begin
    case (req_size)
      SZ_B:    mem_wdata = {4{st_data[7:0]}};
      SZ_H:    mem_wdata = {2{st_data[15:0]}};
      default: mem_wdata = st_data;
    endcase
  end

  logic       q_valid, q_uns, q_bad;
  logic [1:0] q_size, q_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_uns   <= 1'b0;
      q_bad   <= 1'b0;
      q_size  <= 2'b00;
      q_off   <= 2'b00;
    end else begin
      q_valid <= req_valid & ~req_store;
      if (req_valid & ~req_store) begin
        q_uns  <= unsigned_ld;
        q_bad  <= bad;
        q_size <= req_size;
        q_off  <= off;
      end
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    case (q_off)
      2'd0:    sel_b = mem_rdata[31:24];
      2'd1:    sel_b = mem_rdata[23:16];
      2'd2:    sel_b = mem_rdata[15:8];
      default: sel_b = mem_rdata[7:0];
    endcase
    sel_h = q_off[1] ? mem_rdata[15:0] : mem_rdata[31:16];
  end

  always_comb begin
    if (q_bad)
      ld_data = 32'h0;
    else begin
      case (q_size)
        SZ_B:    ld_data = {{24{~q_uns & sel_b[7]}}, sel_b};
        SZ_H:    ld_data = {{16{~q_uns & sel_h[15]}}, sel_h};
        default: ld_data = mem_rdata;
      endcase
    end
  end
  assign ld_valid = q_valid;

  p_mis_blocks_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_re));

  p_mis_load_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && misalign) |=> (ld_valid && ld_data == 32'h0));

  p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |-> ($countones(mem_be) == 0 || $countones(mem_be) == 1 ||
                                  $countones(mem_be) == 2 || $countones(mem_be) == 4));

  p_word_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b10 && !misalign) |-> mem_be == 4'b1111);

  p_load_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |=> ld_valid);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_store) |=> !ld_valid);

  p_word_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && req_size == 2'b10 && !misalign) |=> ld_data == mem_rdata);

  p_zero_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && unsigned_ld && req_size == SZ_B) |=> ld_data[31:8] == 24'h0);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_be == 4'b0000 && !mem_re && !misalign));
endmodule

// File: tb/be_lane_unit_test.sv
module be_lane_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, unsigned_ld = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] base = 32'h0, st_data = 32'h0;
  logic [15:0] disp = 16'h0;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [31:0] mem_rdata = 32'h0;
  logic [3:0]  mem_be;
  logic        mem_re, misalign, ld_valid;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  be_lane_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .unsigned_ld(unsigned_ld), .base(base), .disp(disp),
    .st_data(st_data), .mem_addr(mem_addr), .mem_re(mem_re), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .misalign(misalign),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  function automatic logic [31:0] pat(input logic [29:0] w);
    return 32'h8C41F27E ^ {4{w[7:0]}};
  endfunction

  always @(posedge clk)
    mem_rdata <= mem_re ? pat(mem_addr[31:2]) : 32'hA5A5A5A5;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic st, input logic [1:0] sz, input logic uns,
                        input logic [31:0] b, input logic [15:0] d, input logic [31:0] sd);
    logic [31:0] ea, w, r;
    logic [1:0]  o;
    logic        bad;
    logic [3:0]  ebe;
    logic [31:0] ewd;
    logic [7:0]  by;
    logic [15:0] hw;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; unsigned_ld = uns;
    base = b; disp = d; st_data = sd;
    #1;
    ea  = b + {{16{d[15]}}, d};
    o   = ea[1:0];
    bad = (sz == 2'b00) ? 1'b0 : (sz == 2'b01) ? o[0] : (o != 2'b00);
    chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk("R2 misalign", {31'h0, misalign}, {31'h0, bad});
    if (bad) begin
      chk("R3 be blocked", {28'h0, mem_be}, 32'h0);
      chk("R3 re blocked", {31'h0, mem_re}, 32'h0);
    end
    if (st) begin
      chk("R6 no read on store", {31'h0, mem_re}, 32'h0);
      if (!bad) begin
        case (sz)
          2'b00: begin ebe = 4'b1000 >> o; ewd = {4{sd[7:0]}}; end
          2'b01: begin ebe = o[1] ? 4'b0011 : 4'b1100; ewd = {2{sd[15:0]}}; end
          default: begin ebe = 4'b1111; ewd = sd; end
        endcase
        chk("R4 byte enables", {28'h0, mem_be}, {28'h0, ebe});
        chk("R5 write data", mem_wdata, ewd);
      end
    end else begin
      if (!bad) chk("R6 read strobe", {31'h0, mem_re}, 32'h1);
      chk("R6 no write on load", {28'h0, mem_be}, 32'h0);
      w  = pat(ea[31:2]);
      by = 8'(w >> (8 * (3 - o)));
      hw = o[1] ? w[15:0] : w[31:16];
      if (bad) r = 32'h0;
      else if (sz == 2'b00) r = uns ? {24'h0, by} : {{24{by[7]}}, by};
      else if (sz == 2'b01) r = uns ? {16'h0, hw} : {{16{hw[15]}}, hw};
      else r = w;
      exp_q.push_back(r);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    #1;
    chk("R9 idle be", {28'h0, mem_be}, 32'h0);
    chk("R9 idle re", {31'h0, mem_re}, 32'h0);
    chk("R9 idle misalign", {31'h0, misalign}, 32'h0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ld_valid) begin
        if (exp_q.size() == 0) chk("R6 unexpected ld_valid", 32'h1, 32'h0);
        else chk("R6 R7 R8 R3 load data", ld_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset ld_valid", {31'h0, ld_valid}, 32'h0);
    chk("R9 reset be", {28'h0, mem_be}, 32'h0);
    rst_n = 1'b1;
    idle();
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 5; k++) begin
        logic [1:0] sz;
        logic uns;
        sz  = (k == 4) ? 2'b10 : 2'(k % 2);
        uns = (k >= 2 && k < 4);
        do_req(1'b0, sz, uns, 32'h0000_1000 + 32'(a * 37), 16'h0000, 32'h0);
        do_req(1'b0, sz, uns, 32'h0000_2000 + 32'(a * 4), 16'(a), 32'h0);
      end
    end
    do_req(1'b0, 2'b00, 1'b0, 32'h0000_0100, 16'hFFFC, 32'h0);
    do_req(1'b0, 2'b01, 1'b0, 32'h0001_0002, 16'h8000, 32'h0);
    do_req(1'b0, 2'b10, 1'b0, 32'hFFFF_FFF8, 16'h0010, 32'h0);
    do_req(1'b0, 2'b01, 1'b1, 32'h0000_0301, 16'h0000, 32'h0);
    do_req(1'b0, 2'b10, 1'b0, 32'h0000_0302, 16'h0000, 32'h0);
    do_req(1'b0, 2'b11, 1'b0, 32'h0000_0301, 16'h0000, 32'h0);
    idle();
    for (int a = 0; a < 4; a++) begin
      do_req(1'b1, 2'b00, 1'b0, 32'h0000_4000, 16'(a), 32'h1234_56A7 + 32'(a));
      do_req(1'b1, 2'b01, 1'b0, 32'h0000_4000, 16'(a), 32'hCAFE_8001);
      do_req(1'b1, 2'b10, 1'b0, 32'h0000_4000, 16'(a), 32'h8765_4321);
    end
    do_req(1'b1, 2'b10, 1'b0, 32'h0000_5000, 16'hFFF8, 32'h0BAD_F00D);
    do_req(1'b0, 2'b00, 1'b1, 32'h0000_1003, 16'h0000, 32'h0);
    do_req(1'b1, 2'b01, 1'b0, 32'h0000_5003, 16'h0000, 32'hFFFF);
    idle();
    idle();
    idle();
    chk("R6 all loads returned", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule